// File: doc/BRIEF.md
# Receive Frame Buffer Writer for 2.4 GHz Low-Rate Packets

This block sits behind the demodulator of a low-rate wireless receiver. Once the start-of-frame delimiter has been found, the demodulator hands over one byte per valid cycle. The first byte is the PHY length and the PSDU bytes follow it. The block never sees or stores the preamble or the delimiter. It writes the length byte, then the PSDU with its two-byte FCS left in place, then one link-quality byte and one signal-strength byte. All of these go into a byte-addressed receive buffer starting at a fixed base address, so a frame fills length+3 consecutive locations.

The buffer has two banks. Every frame is written into the bank the host is not reading. A frame becomes visible only when it is committed. Commit requires two things: the CRC-16 over the PSDU must check out, and the address-filter verdict must be a pass. On commit the block flips the host-visible bank and raises a sticky receive flag. A rejected frame changes neither the visible bank nor the flag.

A host read of the status register clears the flag. While the flag is set, incoming frames are counted through and dropped. An abort from the demodulator discards the frame in progress.

Top module: `rxfb_writer`

## Requirements
- R1: A length byte in the range 5 to 127, arriving while the flag is clear, is written at offset 0 (address BASE) one cycle after it is presented.
- R2: PSDU byte i (i = 0 .. length-1, with the FCS in the last two positions) is written at BASE+1+i one cycle after it is presented.
- R3: The LQI byte is written at BASE+1+length in the cycle after the last PSDU write. The RSSI byte is written at BASE+2+length in the next cycle. A stored frame makes exactly length+3 writes, all within BASE .. BASE+MAX_LEN+2.
- R4: A length byte below 5 or above 127 causes no writes for itself or for the length bytes that follow it. The flag and the visible bank stay unchanged, and the byte after those is taken as a new length.
- R5: The FCS check is CRC-16 with polynomial x^16+x^12+x^5+1 and initial value 0. Bits are processed least significant first, the FCS is sent low byte first, and a good frame leaves a zero remainder. On a mismatch there is no commit.
- R6: The filter verdict is sampled together with the last PSDU byte. If it is low there, there is no commit, whatever it does afterwards.
- R7: On acceptance, rx_flag rises and rd_bank toggles on the third rising edge after the edge that captured the last PSDU byte. Writes always go to the bank opposite rd_bank.
- R8: A rejected frame leaves rd_bank and rx_flag unchanged. rd_bank never changes without rx_flag rising.
- R9: A status_rd pulse while the flag is set clears rx_flag on the next edge.
- R10: While rx_flag is set, a new frame produces no writes and no commit, and its bytes are skipped according to its length.
- R11: in_abort during a frame stops all further writes, prevents commit, and makes the next valid byte a length byte.
- R12: After reset, wr_en, rx_flag and rd_bank are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A demodulated byte is present |
| in_byte | input | 8 | Demodulated byte (length first, then PSDU) |
| in_abort | input | 1 | Demodulator gave up on the current frame |
| filter_pass | input | 1 | Address-filter verdict, sampled with the last PSDU byte |
| lqi_val | input | 8 | Link-quality value of the current frame |
| rssi_val | input | 8 | Signal-strength value of the current frame |
| status_rd | input | 1 | Host reads the status register; clears the flag |
| wr_en | output | 1 | Buffer write strobe |
| wr_bank | output | 1 | Bank being written (opposite of rd_bank) |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| rd_bank | output | 1 | Bank holding the last committed frame |
| rx_flag | output | 1 | Sticky receive flag |

## Verification
Every buffer write is due exactly one edge after the byte that causes it. The LQI and RSSI writes follow on the next two edges. The commit (flag rise and bank toggle) falls on the third edge after the last PSDU byte, and a status read clears the flag on the next edge. The bench drives on falling edges and samples 1 ns after falling edges, at exactly these counts. It also checks that the flag has not yet changed one cycle before the commit is due. It flips the filter input right after the last byte to show that the verdict is taken at that edge, and it counts writes per frame against length+3 or zero.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

   typedef enum logic [2:0] {
      ST_LEN,
      ST_BODY,
      ST_SKIP,
      ST_LQI,
      ST_RSSI,
      ST_COMMIT
   } seq_st_t;

   function automatic logic [15:0] rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

endpackage

// File: rtl/rxfb_crc16.sv
module rxfb_crc16 #(
   parameter logic [15:0] POLY      = 16'h1021,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        step,
   input  logic [7:0]  din,
   output logic [15:0] crc_next
);
   import rxfb_pkg::*;

   localparam logic [15:0] POLY_REV = rev16(POLY);

   logic [15:0] crc_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            logic [15:0] c;
            c = crc_q;
            for (int b = 0; b < 8; b++) begin
               if (c[0] ^ din[b]) c = {1'b0, c[15:1]} ^ POLY_REV;
               else               c = {1'b0, c[15:1]};
            end
            crc_next = c;
         end
      end else begin : g_msb
         always_comb begin
            logic [15:0] c;
            c = crc_q;
            for (int b = 7; b >= 0; b--) begin
               if (c[15] ^ din[b]) c = {c[14:0], 1'b0} ^ POLY;
               else                c = {c[14:0], 1'b0};
            end
            crc_next = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clear) crc_q <= '0;
      else if (step)  crc_q <= crc_next;
   end

endmodule

// File: rtl/rxfb_seq.sv
module rxfb_seq #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned BASE    = 768,
   parameter int unsigned MIN_LEN = 5,
   parameter int unsigned MAX_LEN = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_abort,
   input  logic              filter_pass,
   input  logic [7:0]        lqi_val,
   input  logic [7:0]        rssi_val,
   input  logic              flag_q,
   input  logic [15:0]       crc_next,
   output logic              crc_clear,
   output logic              crc_step,
   output logic              commit,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   import rxfb_pkg::*;

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [7:0]        MIN_B  = 8'(MIN_LEN);
   localparam logic [7:0]        MAX_B  = 8'(MAX_LEN);

   seq_st_t    st;
   logic [7:0] len_q;
   logic [7:0] idx_q;
   logic       accept_q;
   logic       len_ok;
   logic       last_byte;
   logic       in_frame;

   assign len_ok    = (in_byte >= MIN_B) && (in_byte <= MAX_B);
   assign last_byte = (idx_q == len_q - 8'd1);
   assign in_frame  = (st == ST_BODY) || (st == ST_SKIP);

   assign crc_clear = (st == ST_LEN) && in_valid;
   assign crc_step  = (st == ST_BODY) && in_valid && !in_abort;
   assign commit    = (st == ST_COMMIT) && accept_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_LEN;
         len_q    <= '0;
         idx_q    <= '0;
         accept_q <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (in_abort && in_frame) begin
            st <= ST_LEN;
         end else begin
            case (st)
               ST_LEN: begin
                  if (in_valid) begin
                     len_q <= in_byte;
                     idx_q <= '0;
                     if (!flag_q && len_ok) begin
                        wr_en   <= 1'b1;
                        wr_addr <= BASE_A;
                        wr_data <= in_byte;
                        st      <= ST_BODY;
                     end else if (in_byte != 8'd0) begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_BODY: begin
                  if (in_valid) begin
                     wr_en   <= 1'b1;
                     wr_addr <= BASE_A + ADDR_W'(idx_q) + ADDR_W'(1);
                     wr_data <= in_byte;
                     idx_q   <= idx_q + 8'd1;
                     if (last_byte) begin
                        accept_q <= (crc_next == 16'h0000) && filter_pass;
                        st       <= ST_LQI;
                     end
                  end
               end
               ST_SKIP: begin
                  if (in_valid) begin
                     idx_q <= idx_q + 8'd1;
                     if (last_byte) st <= ST_LEN;
                  end
               end
               ST_LQI: begin
                  wr_en   <= 1'b1;
                  wr_addr <= BASE_A + ADDR_W'(len_q) + ADDR_W'(1);
                  wr_data <= lqi_val;
                  st      <= ST_RSSI;
               end
               ST_RSSI: begin
                  wr_en   <= 1'b1;
                  wr_addr <= BASE_A + ADDR_W'(len_q) + ADDR_W'(2);
                  wr_data <= rssi_val;
                  st      <= ST_COMMIT;
               end
               default: st <= ST_LEN;
            endcase
         end
      end
   end

endmodule

// File: rtl/rxfb_flag.sv
module rxfb_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic status_rd,
   output logic rx_flag,
   output logic rd_bank
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_flag <= 1'b0;
         rd_bank <= 1'b0;
      end else begin
         if (commit) begin
            rx_flag <= 1'b1;
            rd_bank <= ~rd_bank;
         end else if (status_rd) begin
            rx_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rxfb_writer.sv
module rxfb_writer #(
   parameter int unsigned ADDR_W        = 10,
   parameter int unsigned BASE          = 768,
   parameter int unsigned MIN_LEN       = 5,
   parameter int unsigned MAX_LEN       = 127,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter bit          CRC_LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_abort,
   input  logic              filter_pass,
   input  logic [7:0]        lqi_val,
   input  logic [7:0]        rssi_val,
   input  logic              status_rd,
   output logic              wr_en,
   output logic              wr_bank,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              rd_bank,
   output logic              rx_flag
);

   generate
      if (ADDR_W < 8 || ADDR_W > 24)
         $error("rxfb_writer: ADDR_W must be 8..24");
      if (MIN_LEN < 3 || MIN_LEN > MAX_LEN)
         $error("rxfb_writer: MIN_LEN must be >= 3 and <= MAX_LEN");
      if (MAX_LEN > 255)
         $error("rxfb_writer: MAX_LEN must fit in a byte");
      if (BASE + MAX_LEN + 2 >= (1 << ADDR_W))
         $error("rxfb_writer: frame window exceeds address space");
   endgenerate

   logic        crc_clear;
   logic        crc_step;
   logic        commit;
   logic [15:0] crc_next;

   rxfb_crc16 #(
      .POLY      (CRC_POLY),
      .LSB_FIRST (CRC_LSB_FIRST)
   ) crc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (crc_clear),
      .step     (crc_step),
      .din      (in_byte),
      .crc_next (crc_next)
   );

   rxfb_seq #(
      .ADDR_W  (ADDR_W),
      .BASE    (BASE),
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_byte     (in_byte),
      .in_abort    (in_abort),
      .filter_pass (filter_pass),
      .lqi_val     (lqi_val),
      .rssi_val    (rssi_val),
      .flag_q      (rx_flag),
      .crc_next    (crc_next),
      .crc_clear   (crc_clear),
      .crc_step    (crc_step),
      .commit      (commit),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data)
   );

   rxfb_flag flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .status_rd (status_rd),
      .rx_flag   (rx_flag),
      .rd_bank   (rd_bank)
   );

   assign wr_bank = ~rd_bank;

endmodule

// File: rtl/rxfb_chk.sv
module rxfb_chk #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned BASE    = 768,
   parameter int unsigned MIN_LEN = 5,
   parameter int unsigned MAX_LEN = 127
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              rx_flag,
   input logic              rd_bank,
   input logic              status_rd
);

   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE + MAX_LEN + 2);

   AST_FLAG_WITH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> (rd_bank != $past(rd_bank))); // R7

   AST_BANK_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bank != $past(rd_bank)) |-> $rose(rx_flag)); // R8

   AST_NO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rx_flag); // R10

   AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr >= LO_A && wr_addr <= HI_A)); // R3

   AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == LO_A) |-> (wr_data >= 8'(MIN_LEN) && wr_data <= 8'(MAX_LEN))); // R4

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && rx_flag) |=> !rx_flag); // R9

endmodule

bind rxfb_writer rxfb_chk #(
   .ADDR_W  (ADDR_W),
   .BASE    (BASE),
   .MIN_LEN (MIN_LEN),
   .MAX_LEN (MAX_LEN)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rx_flag   (rx_flag),
   .rd_bank   (rd_bank),
   .status_rd (status_rd)
);

// File: tb/rxfb_writer_tb_top.sv
`timescale 1ns/1ps
module rxfb_writer_tb_top;

   localparam int ADDR_W = 10;
   localparam int BASE   = 768;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_byte = '0;
   logic              in_abort = 1'b0;
   logic              filter_pass = 1'b0;
   logic [7:0]        lqi_val = '0;
   logic [7:0]        rssi_val = '0;
   logic              status_rd = 1'b0;
   logic              wr_en;
   logic              wr_bank;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic              rd_bank;
   logic              rx_flag;

   always #10 clk = ~clk;

   rxfb_writer #(.ADDR_W(ADDR_W), .BASE(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_abort(in_abort), .filter_pass(filter_pass), .lqi_val(lqi_val),
      .rssi_val(rssi_val), .status_rd(status_rd), .wr_en(wr_en),
      .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_bank(rd_bank), .rx_flag(rx_flag)
   );

   int         n_checks = 0;
   int         n_fail   = 0;
   int         wr_cnt   = 0;
   int         bank_err = 0;
   logic [7:0] shadow [2][256];
   logic [7:0] frm [256];

   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         shadow[wr_bank][(int'(wr_addr) - BASE) & 255] = wr_data;
         wr_cnt++;
         if (wr_bank == rd_bank) bank_err++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] fcs16(input int n);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i < n; i++)
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ frm[i][b]) c = (c >> 1) ^ 16'h8408;
            else                  c = c >> 1;
         end
      return c;
   endfunction

   task automatic run_frame(input int len, input bit bad_crc, input bit pass, input string req);
      logic       flag0, bank0;
      int         w0, e0, bad;
      bit         stored, commit;
      logic [7:0] lq, rs;
      logic [15:0] f;
      for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
      if (len >= 5 && len <= 127) begin
         f = fcs16(len - 2);
         frm[len-2] = f[7:0];
         frm[len-1] = f[15:8];
         if (bad_crc) frm[1] = frm[1] ^ 8'h40;
      end
      lq = 8'($urandom); rs = 8'($urandom);
      flag0 = rx_flag; bank0 = rd_bank; w0 = wr_cnt; e0 = bank_err;
      stored = !flag0 && len >= 5 && len <= 127;
      commit = stored && !bad_crc && pass;
      @(negedge clk);
      filter_pass = pass; lqi_val = lq; rssi_val = rs;
      in_valid = 1'b1; in_byte = 8'(len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_byte = frm[i];
      end
      @(negedge clk);
      in_valid = 1'b0; filter_pass = ~pass;
      @(negedge clk);
      @(negedge clk); #1;
      chk(rx_flag == flag0, {req, " R7 flag not before third edge"}, rx_flag, flag0);
      @(negedge clk); #1;
      chk(rx_flag == (commit ? 1'b1 : flag0), {req, " R8 flag after frame"}, rx_flag, commit ? 1 : flag0);
      chk(rd_bank == (commit ? ~bank0 : bank0), {req, " R7 visible bank"}, rd_bank, commit ? ~bank0 : bank0);
      chk(wr_cnt - w0 == (stored ? len + 3 : 0), {req, " R3 write count"}, wr_cnt - w0, stored ? len + 3 : 0);
      chk(bank_err == e0, {req, " R7 write bank"}, bank_err - e0, 0);
      if (stored) begin
         bad = 0;
         if (shadow[~bank0][0] != 8'(len)) bad++;
         for (int i = 0; i < len; i++) if (shadow[~bank0][i+1] != frm[i]) bad++;
         if (shadow[~bank0][len+1] != lq) bad++;
         if (shadow[~bank0][len+2] != rs) bad++;
         chk(bad == 0, {req, " R1 R2 R3 buffer layout"}, bad, 0);
      end
   endtask

   task automatic clear_flag();
      @(negedge clk); status_rd = 1'b1;
      @(negedge clk); status_rd = 1'b0; #1;
      chk(rx_flag == 1'b0, "R9 status read clears flag", rx_flag, 0);
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int w0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      chk(wr_en == 1'b0, "R12 reset wr_en", wr_en, 0);
      chk(rx_flag == 1'b0, "R12 reset rx_flag", rx_flag, 0);
      chk(rd_bank == 1'b0, "R12 reset rd_bank", rd_bank, 0);
      @(negedge clk); rst_n = 1'b1;

      run_frame(5, 0, 1, "R1 min length");
      clear_flag();
      run_frame(127, 0, 1, "R2 max length");
      clear_flag();
      run_frame(20, 1, 1, "R5 corrupt fcs");
      run_frame(20, 0, 0, "R6 filter reject");
      run_frame(12, 0, 1, "R7 accept");
      run_frame(30, 0, 1, "R10 flag set drops");
      clear_flag();
      run_frame(5, 0, 1, "R10 after skip");
      clear_flag();
      run_frame(4, 0, 1, "R4 short length");
      run_frame(128, 0, 1, "R4 long length");
      run_frame(200, 0, 1, "R4 oversize");
      run_frame(0, 0, 1, "R4 zero length");
      run_frame(9, 0, 1, "R4 after bad lengths");
      clear_flag();

      w0 = wr_cnt;
      @(negedge clk); in_valid = 1'b1; in_byte = 8'd20;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); in_byte = 8'($urandom);
      end
      @(negedge clk); in_valid = 1'b0; in_abort = 1'b1;
      @(negedge clk); in_abort = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      chk(wr_cnt - w0 == 7, "R11 writes stop at abort", wr_cnt - w0, 7);
      chk(rx_flag == 1'b0, "R11 no commit after abort", rx_flag, 0);
      run_frame(9, 0, 1, "R11 next byte is length");
      clear_flag();

      for (int k = 0; k < 25; k++) begin
         int  len  = 5 + int'($urandom % 123);
         bit  bc   = ($urandom % 5) == 0;
         bit  pass = ($urandom % 5) != 0;
         run_frame(len, bc, pass, "R2 R5 R6 random");
         if (rx_flag) clear_flag();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule